// File: doc/BRIEF.md
# Flash Busy Status Readback Generator

This block sits on the read path of a byte-wide flash array and decides what a host sees when it reads while an internal program or erase is running. When the array is idle, reads pass the array byte straight to the bus. While an operation runs, two bits of every read byte are replaced by status. Bit 7 reports completion: for a byte program it is the inverse of bit 7 of the byte being written, and for any erase it is 0. Bit 6 changes value on every read, so a host that reads twice can see that work is still in progress.

The busy period comes from an internal timer. A one-cycle launch pulse from the command decoder carries the operation kind and the byte being programmed. The timer loads a per-kind duration, set in clock cycles by parameters so that simulation stays short. The byte and the kind are captured at launch. Launch pulses that arrive while busy are dropped.

Top module: `opstat_rdback`

## Requirements
- R1: While reset is active and right after it, `busy` is 0 and `rd_data` equals `array_data`.
- R2: An `op_start` pulse sampled while idle raises `busy` at that same clock edge, so status substitution applies from the following cycle.
- R3: While busy with a program operation (`op_kind` = 2'b00), `rd_data[7]` is the inverse of bit 7 of the `prog_byte` captured at launch.
- R4: While busy with an erase (`op_kind` 2'b01 sector, 2'b10 block, 2'b11 chip), `rd_data[7]` is 0.
- R5: While busy, `rd_data[6]` inverts at the clock edge that samples a rising edge of `rd_strobe`. It holds its value between reads.
- R6: While busy, `rd_data[5:0]` equals `array_data[5:0]`.
- R7: While idle, `rd_data` equals `array_data` on every bit, and read strobes change nothing.
- R8: `busy` stays high for exactly PROG_CYC, SECT_CYC, BLOCK_CYC or CHIP_CYC cycles for kinds 2'b00, 2'b01, 2'b10 and 2'b11 respectively.
- R9: An `op_start` pulse that arrives while busy is ignored. It neither restarts the duration nor changes the reported kind.
- R10: A program operation never stays busy for more than PROG_MAX_CYC cycles.
- R11: Changes to `prog_byte` and `op_kind` after launch have no effect on the running operation's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle launch of an array operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| prog_byte | input | 8 | Byte being programmed, captured at launch |
| rd_strobe | input | 1 | Host read strobe; each rising edge is one read access |
| array_data | input | 8 | Byte read from the array at the current address |
| rd_data | output | 8 | Byte returned to the host |
| busy | output | 1 | Internal operation in progress |

## Verification
The assertions assume that the inputs are synchronous to `clk`. They also assume that `rd_strobe` is low for at least one cycle between reads, so that each access produces one rising edge. Finally, they assume that the program duration parameter does not exceed the program limit. The bench drives every input one time unit after a rising edge and returns the strobe low for a full cycle after each read. It uses parameter values with PROG_CYC below PROG_MAX_CYC. It also injects launch pulses and `prog_byte` changes in the middle of operations, so that the held-state properties are exercised against changing inputs.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_SECT  = 2'b01,
    OP_BLOCK = 2'b10,
    OP_CHIP  = 2'b11
  } op_kind_e;

  // Busy duration in cycles for one operation kind.
  function automatic int unsigned op_cycles(op_kind_e k, int unsigned p_cyc,
                                            int unsigned s_cyc, int unsigned b_cyc,
                                            int unsigned c_cyc);
    case (k)
      OP_PROG:  return p_cyc;
      OP_SECT:  return s_cyc;
      OP_BLOCK: return b_cyc;
      default:  return c_cyc;
    endcase
  endfunction

  // Byte presented to the host while an operation is running.
  function automatic logic [7:0] status_byte(logic [7:0] arr, op_kind_e k,
                                             logic pbit7, logic tgl);
    logic poll;
    poll = (k == OP_PROG) ? ~pbit7 : 1'b0;
    return {poll, tgl, arr[5:0]};
  endfunction

endpackage

// File: rtl/opstat_timer.sv
module opstat_timer
  import opstat_pkg::*;
#(
  parameter int unsigned PROG_CYC  = 14,
  parameter int unsigned SECT_CYC  = 180,
  parameter int unsigned BLOCK_CYC = 180,
  parameter int unsigned CHIP_CYC  = 700
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  op_kind_e kind_i,
  input  logic     bit7_i,
  output logic     busy_o,
  output op_kind_e kind_o,
  output logic     bit7_o
);
  localparam int unsigned MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_B = (BLOCK_CYC > CHIP_CYC) ? BLOCK_CYC : CHIP_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] remain_q;
  logic             busy_q;
  op_kind_e         kind_q;
  logic             bit7_q;
  logic             launch;
  logic             last_cyc;

  assign launch   = start_i & ~busy_q;
  assign last_cyc = busy_q & (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      kind_q   <= OP_PROG;
      bit7_q   <= 1'b0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      remain_q <= CNT_W'(op_cycles(kind_i, PROG_CYC, SECT_CYC, BLOCK_CYC, CHIP_CYC) - 1);
      kind_q   <= kind_i;
      bit7_q   <= bit7_i;
    end else if (busy_q) begin
      if (last_cyc) busy_q <= 1'b0;
      else          remain_q <= remain_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign bit7_o = bit7_q;

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && kind_o == $past(kind_i))); // R2
  AST_LAST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_cyc |=> !busy_o); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(kind_o) && $stable(bit7_o))); // R9
  AST_HELD_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(kind_o) && $stable(bit7_o))); // R11

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_i,
  output logic tgl_o
);
  logic rd_prev_q;
  logic tgl_q;
  logic rd_rise;

  assign rd_rise = rd_i & ~rd_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b0;
      tgl_q     <= 1'b0;
    end else begin
      rd_prev_q <= rd_i;
      if (busy_i && rd_rise) tgl_q <= ~tgl_q;
    end
  end

  assign tgl_o = tgl_q;

  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_rise) |=> (tgl_o != $past(tgl_o))); // R5
  AST_TGL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_i && rd_rise) |=> $stable(tgl_o)); // R5

endmodule

// File: rtl/opstat_mux.sv
module opstat_mux
  import opstat_pkg::*;
(
  input  logic       busy_i,
  input  op_kind_e   kind_i,
  input  logic       bit7_i,
  input  logic       tgl_i,
  input  logic [7:0] arr_i,
  output logic [7:0] data_o
);
  always_comb begin
    if (busy_i) data_o = status_byte(arr_i, kind_i, bit7_i, tgl_i);
    else        data_o = arr_i;
  end
endmodule

// File: rtl/opstat_rdback.sv
module opstat_rdback
  import opstat_pkg::*;
#(
  parameter int unsigned PROG_CYC     = 14,
  parameter int unsigned PROG_MAX_CYC = 20,
  parameter int unsigned SECT_CYC     = 180,
  parameter int unsigned BLOCK_CYC    = 180,
  parameter int unsigned CHIP_CYC     = 700
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic [1:0] op_kind,
  input  logic [7:0] prog_byte,
  input  logic       rd_strobe,
  input  logic [7:0] array_data,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam int unsigned RUN_W = $clog2(PROG_MAX_CYC + 2);

  logic     busy_w;
  op_kind_e kind_w;
  logic     bit7_w;
  logic     tgl_w;

  opstat_timer #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .BLOCK_CYC(BLOCK_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(op_start),
    .kind_i (op_kind_e'(op_kind)),
    .bit7_i (prog_byte[7]),
    .busy_o (busy_w),
    .kind_o (kind_w),
    .bit7_o (bit7_w)
  );

  opstat_toggle toggle_i (
    .clk   (clk),
    .rst_n (rst_n),
    .busy_i(busy_w),
    .rd_i  (rd_strobe),
    .tgl_o (tgl_w)
  );

  opstat_mux mux_i (
    .busy_i(busy_w),
    .kind_i(kind_w),
    .bit7_i(bit7_w),
    .tgl_i (tgl_w),
    .arr_i (array_data),
    .data_o(rd_data)
  );

  assign busy = busy_w;

  // Length of the running program operation, saturating; guards the limit.
  logic [RUN_W-1:0] prog_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_w || kind_w != OP_PROG) prog_run_q <= '0;
    else if (prog_run_q != {RUN_W{1'b1}}) prog_run_q <= prog_run_q + 1'b1;
  end

  AST_PROG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_run_q <= RUN_W'(PROG_MAX_CYC))); // R10
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_w == OP_PROG) |-> (rd_data[7] == ~bit7_w)); // R3
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_w != OP_PROG) |-> (rd_data[7] == 1'b0)); // R4
  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[5:0] == array_data[5:0])); // R6
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == array_data)); // R7

endmodule

// File: tb/opstat_rdback_tb.sv
module opstat_rdback_tb_top;
  localparam int unsigned T_PROG  = 8;
  localparam int unsigned T_PMAX  = 10;
  localparam int unsigned T_SECT  = 12;
  localparam int unsigned T_BLOCK = 14;
  localparam int unsigned T_CHIP  = 20;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] pbyte;
    logic [7:0] arr;
    logic       poll;
    logic [7:0] dur;
  } vec_t;

  localparam vec_t [0:5] VEC = '{
    '{2'b00, 8'h80, 8'h3C, 1'b0, 8'(T_PROG)},
    '{2'b00, 8'h7F, 8'hA5, 1'b1, 8'(T_PROG)},
    '{2'b01, 8'hFF, 8'h5A, 1'b0, 8'(T_SECT)},
    '{2'b10, 8'h00, 8'hC3, 1'b0, 8'(T_BLOCK)},
    '{2'b11, 8'h12, 8'h81, 1'b0, 8'(T_CHIP)},
    '{2'b00, 8'h00, 8'hFF, 1'b1, 8'(T_PROG)}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_start = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [7:0] prog_byte = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;
  logic       busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  opstat_rdback #(
    .PROG_CYC(T_PROG), .PROG_MAX_CYC(T_PMAX), .SECT_CYC(T_SECT),
    .BLOCK_CYC(T_BLOCK), .CHIP_CYC(T_CHIP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_byte(prog_byte), .rd_strobe(rd_strobe), .array_data(array_data),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    finish_up();
  end

  initial begin
    logic [7:0] d_hi;
    logic [7:0] d_lo;
    logic       prev6;
    int         t0;
    int         dur;

    // R1: reset state
    array_data = 8'h96;
    step();
    chk(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
    chk(rd_data == 8'h96, "R1 data in reset", 32'(rd_data), 32'h96);
    step();
    rst_n = 1'b1;
    step();
    chk(rd_data == 8'h96 && !busy, "R1 after reset", 32'(rd_data), 32'h96);

    for (int i = 0; i < 6; i++) begin
      array_data = VEC[i].arr;
      prog_byte  = VEC[i].pbyte;
      op_kind    = VEC[i].kind;
      op_start   = 1'b1;
      step();
      op_start   = 1'b0;
      t0 = cyc;
      chk(busy == 1'b1, "R2 busy after launch", 32'(busy), 1);
      // R11: input changes after launch must not matter
      prog_byte = ~VEC[i].pbyte;
      op_kind   = ~VEC[i].kind;
      prev6 = 1'b0;
      for (int r = 0; r < 3; r++) begin
        rd_strobe = 1'b1;
        step();
        d_hi = rd_data;
        rd_strobe = 1'b0;
        step();
        d_lo = rd_data;
        chk(d_hi[7] == VEC[i].poll, VEC[i].kind == 2'b00 ? "R3 R11 program poll bit" :
            "R4 R11 erase poll bit", 32'(d_hi[7]), 32'(VEC[i].poll));
        chk(d_hi[5:0] == VEC[i].arr[5:0], "R6 low bits pass", 32'(d_hi[5:0]),
            32'(VEC[i].arr[5:0]));
        chk(d_lo == d_hi, "R5 toggle holds between reads", 32'(d_lo), 32'(d_hi));
        if (r > 0) chk(d_hi[6] != prev6, "R5 toggle flips", 32'(d_hi[6]), 32'(~prev6));
        prev6 = d_hi[6];
      end
      // R9: a launch while busy is dropped
      op_start = 1'b1;
      step();
      op_start = 1'b0;
      chk(rd_data[7] == VEC[i].poll, "R9 kind kept on relaunch", 32'(rd_data[7]),
          32'(VEC[i].poll));
      while (busy) step();
      dur = cyc - t0;
      chk(dur == int'(VEC[i].dur), "R8 R9 busy duration", 32'(dur), 32'(VEC[i].dur));
      if (VEC[i].kind == 2'b00)
        chk(dur <= int'(T_PMAX), "R10 program within limit", 32'(dur), 32'(T_PMAX));
      // R7: idle reads pass through unchanged
      rd_strobe = 1'b1;
      step();
      chk(rd_data == VEC[i].arr, "R7 idle passthrough", 32'(rd_data), 32'(VEC[i].arr));
      rd_strobe = 1'b0;
      array_data = 8'h4E;
      step();
      chk(rd_data == 8'h4E, "R7 idle follows array", 32'(rd_data), 32'h4E);
    end

    // R2: launch immediately after completion is accepted
    op_kind = 2'b01;
    op_start = 1'b1;
    step();
    op_start = 1'b0;
    t0 = cyc;
    array_data = 8'hFF;
    chk(busy && rd_data[7] == 1'b0, "R2 R4 back-to-back launch", 32'(rd_data), 32'h7F);
    while (busy) step();
    dur = cyc - t0;
    chk(dur == int'(T_SECT), "R8 sector duration", 32'(dur), 32'(T_SECT));
    chk(rd_data == 8'hFF, "R7 erased byte after end", 32'(rd_data), 32'hFF);

    // R1: reset during an operation returns to idle
    op_kind = 2'b11;
    op_start = 1'b1;
    step();
    op_start = 1'b0;
    rst_n = 1'b0;
    step();
    chk(!busy && rd_data == 8'hFF, "R1 reset aborts", 32'(busy), 0);
    rst_n = 1'b1;
    step();
    finish_up();
  end
endmodule